// File: doc/BRIEF.md
# Staggered Slice Pipelined Adder

This block is a 64-bit integer adder that spreads one addition over four pipeline stages. Each stage handles one 16-bit slice: the first stage adds the low slice, and each later stage adds the next slice up, using the carry registered by the stage before it. Operand slices that are not needed yet ride down the pipeline in registers until their stage comes up. The full sum leaves the last stage four cycles after the operands are accepted.

The pipeline is staggered. A dependent add does not wait for the whole 64-bit result of the add it depends on. Each input operand has a forward flag. When the flag is set, the operand means "the result of the add accepted in the previous cycle". Stage k then reads slice k of that operand straight from the slice-k result that the producer wrote one cycle earlier. As a result, a chain of dependent adds can be issued on every cycle. Cycles with no valid operation pass through the pipeline as bubbles and produce no output.

Top module: `staggered_slice_adder`

## Requirements
- R1: While reset is held, and in the cycles after reset until the first accepted operation has come through, `out_valid` is 0.
- R2: For an accepted operation with both forward flags clear, `out_sum` equals `in_a + in_b` modulo 2^64.
- R3: Each accepted operation produces exactly one result, in issue order. The result is presented with `out_valid` high exactly four rising clock edges after the edge that accepted it.
- R4: A carry produced in any 16-bit slice reaches every higher slice. Examples: `0xFFFF + 1` gives `0x1_0000`, and all-ones plus 1 gives 0.
- R5: With `in_fwd_a` set, operand A is replaced by the 64-bit result of the operation accepted in the immediately preceding cycle, and `in_a` is ignored.
- R6: With `in_fwd_b` set, operand B is replaced in the same way and `in_b` is ignored. With both flags set, the result is twice the previous result.
- R7: Dependent operations can be accepted on consecutive cycles without limit, and results still appear one per cycle.
- R8: A cycle with `in_valid` low produces no result. While `out_valid` is low, `out_sum` keeps the last result that was presented.
- R9: A forward flag may be set only when an operation was accepted in the preceding cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation accepted this cycle |
| in_a | input | 64 | Operand A |
| in_b | input | 64 | Operand B |
| in_fwd_a | input | 1 | Operand A takes the previous operation's result |
| in_fwd_b | input | 1 | Operand B takes the previous operation's result |
| out_valid | output | 1 | Result present |
| out_sum | output | 64 | 64-bit sum |

## Verification
The bench goes after carries that cross slice boundaries, including a forwarded operand whose carry ripples through three slices. A design that drops the registered carry would return the slice-wise sum without the carry, so the upper slices would come out wrong. It also drives back-to-back dependent chains through A, through B and through both operands at once. If the forwarding picks the wrong stage, the upper slices would hold the result from two operations back or a stale stored operand. Bubbles are mixed in at random to catch three faults: a result emitted for an empty slot, a result arriving at the wrong latency, and `out_sum` drifting while no result is present.

// File: rtl/staggered_slice_adder.sv
module staggered_slice_adder #(
  parameter int W = 64,
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  input  logic         in_fwd_a,
  input  logic         in_fwd_b,
  output logic         out_valid,
  output logic [W-1:0] out_sum
);
  localparam int SW = W / N;

  // stage registers, index k holds the op that has finished slice k-1
  logic         v_q  [1:N];
  logic         fa_q [1:N];
  logic         fb_q [1:N];
  logic         c_q  [1:N];
  logic [W-1:0] a_q  [1:N];
  logic [W-1:0] b_q  [1:N];
  logic [W-1:0] s_q  [1:N];

  // inputs seen by each stage's slice adder
  logic         src_v  [0:N-1];
  logic         src_fa [0:N-1];
  logic         src_fb [0:N-1];
  logic         src_c  [0:N-1];
  logic [W-1:0] src_a  [0:N-1];
  logic [W-1:0] src_b  [0:N-1];
  logic [W-1:0] src_s  [0:N-1];
  logic         nxt_c  [0:N-1];
  logic [W-1:0] nxt_s  [0:N-1];

  always_comb begin
    src_v[0]  = in_valid;
    src_fa[0] = in_fwd_a;
    src_fb[0] = in_fwd_b;
    src_c[0]  = 1'b0;
    src_a[0]  = in_a;
    src_b[0]  = in_b;
    src_s[0]  = '0;
    for (int k = 1; k < N; k++) begin
      src_v[k]  = v_q[k];
      src_fa[k] = fa_q[k];
      src_fb[k] = fb_q[k];
      src_c[k]  = c_q[k];
      src_a[k]  = a_q[k];
      src_b[k]  = b_q[k];
      src_s[k]  = s_q[k];
    end
  end

  // slice k of a forwarded operand comes from the producer one stage ahead
  always_comb begin
    logic [SW-1:0] opa, opb, sl;
    for (int k = 0; k < N; k++) begin
      opa = src_fa[k] ? s_q[k+1][k*SW +: SW] : src_a[k][k*SW +: SW];
      opb = src_fb[k] ? s_q[k+1][k*SW +: SW] : src_b[k][k*SW +: SW];
      {nxt_c[k], sl} = {1'b0, opa} + {1'b0, opb} + (SW+1)'(src_c[k]);
      nxt_s[k] = src_s[k];
      nxt_s[k][k*SW +: SW] = sl;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 1; k <= N; k++) begin
        v_q[k]  <= 1'b0;
        fa_q[k] <= 1'b0;
        fb_q[k] <= 1'b0;
        c_q[k]  <= 1'b0;
        a_q[k]  <= '0;
        b_q[k]  <= '0;
        s_q[k]  <= '0;
      end
    end else begin
      for (int k = 0; k < N; k++) begin
        v_q[k+1] <= src_v[k];
        if (src_v[k]) begin
          fa_q[k+1] <= src_fa[k];
          fb_q[k+1] <= src_fb[k];
          c_q[k+1]  <= nxt_c[k];
          a_q[k+1]  <= src_a[k];
          b_q[k+1]  <= src_b[k];
          s_q[k+1]  <= nxt_s[k];
        end
      end
    end
  end

  assign out_valid = v_q[N];
  assign out_sum   = s_q[N];

  assert_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##N out_valid);

  assert_bubble_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> ##N !out_valid);

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_sum));

  assert_fwd_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (in_fwd_a || in_fwd_b)) |-> v_q[1]);

  assert_chain_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (v_q[N] && fa_q[N] && !fb_q[N]) |-> (s_q[N] == $past(s_q[N]) + b_q[N]));
endmodule

// File: tb/test_staggered_slice_adder.sv
module test_staggered_slice_adder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] in_a = '0;
  logic [63:0] in_b = '0;
  logic        in_fwd_a = 1'b0;
  logic        in_fwd_b = 1'b0;
  logic        out_valid;
  logic [63:0] out_sum;

  staggered_slice_adder i_staggered_slice_adder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
    .in_fwd_a(in_fwd_a), .in_fwd_b(in_fwd_b), .out_valid(out_valid), .out_sum(out_sum)
  );

  always #4 clk = ~clk;

  int          checks = 0;
  int          fails = 0;
  int          cyc = 0;
  bit          done = 1'b0;
  logic [63:0] exp_sum[$];
  int          exp_cyc[$];
  string       exp_tag[$];
  logic [63:0] last_res = '0;
  bit          prev_v = 1'b0;
  logic [63:0] last_out = '0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, expv, cyc);
    end
  endtask

  task automatic drive(bit v, logic [63:0] a, logic [63:0] b, bit fa, bit fb, string tag);
    logic [63:0] ea, eb;
    @(negedge clk);
    in_valid = v;
    in_a = a;
    in_b = b;
    in_fwd_a = v & fa & prev_v;
    in_fwd_b = v & fb & prev_v;
    if (v) begin
      ea = in_fwd_a ? last_res : a;
      eb = in_fwd_b ? last_res : b;
      last_res = ea + eb;
      exp_sum.push_back(last_res);
      exp_cyc.push_back(cyc + 4);
      exp_tag.push_back(tag);
    end
    prev_v = v;
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (out_valid) begin
        if (exp_sum.size() == 0) begin
          check(1'b0, "R3 unexpected result", out_sum, 64'h0);
        end else begin
          logic [63:0] e;
          int          ec;
          string       t;
          e = exp_sum.pop_front();
          ec = exp_cyc.pop_front();
          t = exp_tag.pop_front();
          check(out_sum === e, t, out_sum, e);
          check(cyc == ec, "R3 latency", 64'(cyc), 64'(ec));
        end
        last_out = out_sum;
      end else begin
        check(out_sum === last_out, "R8 hold", out_sum, last_out);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) begin
      @(negedge clk);
      check(out_valid === 1'b0, "R1 reset", 64'(out_valid), 64'h0);
    end
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid === 1'b0, "R1 after reset", 64'(out_valid), 64'h0);

    drive(1, 64'h0000_0000_0000_FFFF, 64'h1, 0, 0, "R4 slice0 carry");
    drive(1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 0, 0, "R4 full ripple");
    drive(1, 64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_4321, 0, 0, "R2 plain");
    drive(0, 0, 0, 0, 0, "");
    drive(0, 0, 0, 0, 0, "");
    drive(1, 64'h0000_FFFF_FFFF_FFFF, 64'h0, 0, 0, "R2 seed");
    drive(1, 64'hDEAD_BEEF_0000_0000, 64'h1, 1, 0, "R5 fwd A carry R4");
    drive(1, 64'h5, 64'hCAFE_0000_0000_0000, 0, 1, "R6 fwd B");
    drive(0, 0, 0, 0, 0, "");
    drive(1, 64'h3, 64'h0, 0, 0, "R2 seed");
    for (int i = 0; i < 8; i++) drive(1, 64'hAAAA, 64'h5555, 1, 1, "R6 both R7 chain");
    for (int i = 0; i < 12; i++) drive(1, 64'hFFFF, 64'h8000_0000_0000_FFFF, 1, 0, "R7 chain R5");
    drive(0, 0, 0, 0, 0, "");
    for (int i = 0; i < 3000; i++) begin
      bit v;
      v = ($urandom % 5) != 0;
      drive(v, {$urandom, $urandom}, {$urandom, $urandom},
            ($urandom % 2) == 0, ($urandom % 3) == 0, "R2 R5 R6 random");
    end
    drive(0, 0, 0, 0, 0, "");
    repeat (8) @(negedge clk);
    check(exp_sum.size() == 0, "R3 all results", 64'(exp_sum.size()), 64'h0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule